// File: doc/BRIEF.md
# Question-Answer Watchdog Evaluator

This block runs a challenge-response watchdog. It holds a 4-bit question. In every watchdog cycle a host must write four answer bytes, and each byte is a fixed function of the question and of a 2-bit answer index. A watchdog cycle has two back-to-back response windows, and their lengths in clock ticks come from input ports.

A cycle passes only when three correct bytes arrive in the first window and a fourth correct byte arrives in the second window. Any other pattern marks the cycle as failed:

- an answer that arrives too early;
- a missing answer;
- an answer in the wrong window;
- a wrong byte.

A failed cycle sets its own combination of four status flags, raises a saturating failure counter and repeats the same question. A passing cycle lowers the counter and moves to the next question. A threshold output tells the surrounding logic when the failure counter has reached a programmed level.

Top module: `qa_watchdog`

## Requirements
- R1: After reset the outputs are as follows, and the first watchdog cycle starts in response window 1.
  - `question` = 0, `ansIdx` = 3, `statusFlags` = 0, `failCnt` = 0 and `cycleEnd` = 0.
- R2: The expected byte for question q and index i is {hi, lo}, computed as follows.
  - hi = {q[1:0], q[3:2]} XOR (i[0] ? 4'hF : 4'h0).
  - lo = ({q[3:1], 1'b0} XOR (q[0] ? 4'hF : 4'h0)) XOR (i[1] ? 4'hF : 4'h0).
  - Examples: q = 0 gives 0xFF, 0x0F, 0xF0, 0x00 for i = 3, 2, 1, 0; q = 1 gives 0xB0, 0x40, 0xBF, 0x4F.
- R3: `ansIdx` is 3 at the start of every cycle. Each write that does not end the cycle lowers it by one. Each write is compared against the expected byte for the current `ansIdx`.
- R4: Response window 1 covers the first `win1Len` clocks of a cycle. Window 2 covers the next `win2Len` clocks. Both lengths are at least 1.
- R5: A cycle passes when three writes arrive in window 1 and a fourth arrives in window 2, all correct. It ends at the fourth write, with the following results.
  - All flags are 0.
  - `failCnt` decrements, saturating at 0.
  - `question` advances to {q[2:0], q[3] ^ q[2] ^ (q[2:0] == 0)}.
- R6: Four writes inside window 1 end the cycle at the fourth write with the early flag set. The answer-error flag is also set if any of the four writes was wrong.
- R7: If fewer than three writes arrive in window 1 and the fourth write arrives in window 2, the cycle ends at that write with the sequence-error flag set and the timeout flag clear.
- R8: If fewer than four writes have arrived when window 2 closes, the cycle ends there with the timeout flag set. The sequence-error flag is also set when fewer than three writes arrived in window 1.
- R9: Any write whose byte differs from the expected byte sets the answer-error flag of that cycle.
- R10: Every failing cycle has the following effects.
  - `failCnt` increments, saturating at 7.
  - `question` stays the same.
  - `failCnt` does not change between cycle ends.
- R11: The status layout is `statusFlags` = {answer error [3], early [2], sequence error [1], timeout [0]}. The flags are written at each cycle end and hold their value until then. A `statRd` pulse clears them at the next clock.
- R12: `failHit` is 1 exactly when `failCnt` >= `failThresh`.
- R13: `cycleEnd` is high for one clock, in the clock that follows the edge that ended the cycle. The next cycle begins in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ansWr | input | 1 | Answer write strobe |
| ansByte | input | 8 | Answer byte |
| statRd | input | 1 | Status read strobe; clears the flags |
| win1Len | input | TIMER_W | Response window 1 length in clocks |
| win2Len | input | TIMER_W | Response window 2 length in clocks |
| failThresh | input | FAIL_W | Failure counter threshold |
| question | output | 4 | Current question |
| ansIdx | output | 2 | Index of the next expected answer |
| statusFlags | output | 4 | {answer error, early, sequence error, timeout} |
| failCnt | output | FAIL_W | Saturating failure counter |
| failHit | output | 1 | Failure counter at or above threshold |
| cycleEnd | output | 1 | One-clock pulse marking a new watchdog cycle |

## Verification
The bench sweeps every split of up to four writes between the two windows, crossed with every position of a single wrong byte. This separates the following outcomes:

- early endings from sequence errors;
- sequence errors from timeouts;
- correct answers from answer errors.

A run of passing cycles walks the question through all sixteen values and checks every expected byte against the arithmetic formula. Long runs of failing cycles followed by passing cycles drive the failure counter into both saturation limits across the threshold. A status read in every cycle shows that the flags clear.

// File: rtl/qaw_pkg.sv
package qaw_pkg;
  localparam int QUESTION_W = 4;
  localparam int ANSWER_W   = 8;
  localparam int INDEX_W    = 2;

  // Bit order is part of the status port layout.
  typedef struct packed {
    logic ansErr;
    logic early;
    logic seqErr;
    logic timeout;
  } qaw_flags_t;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic       cycleDone;
    logic       cyclePass;
    qaw_flags_t flags;
  } qaw_strobe_t;
endpackage

// File: rtl/qaw_ctrl.sv
module qaw_ctrl
  import qaw_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ansWr,
  input  logic               ansOk,
  input  logic [TIMER_W-1:0] win1Len,
  input  logic [TIMER_W-1:0] win2Len,
  output logic [INDEX_W-1:0] ansIdx,
  output qaw_strobe_t        strobe
);
  localparam int TW = TIMER_W + 1;
  localparam int CW = 3;

  logic               inWin2;
  logic [TIMER_W-1:0] timer;
  logic [CW-1:0]      cntW1, cntW2, total;
  logic               errSeen, errNow, lastAns, win1End, win2End, done;
  logic [TW-1:0]      tickNext;

  assign tickNext = {1'b0, timer} + TW'(1);
  assign win1End  = !inWin2 && (tickNext >= {1'b0, win1Len});
  assign win2End  = inWin2 && (tickNext >= {1'b0, win2Len});
  assign total    = cntW1 + cntW2;
  assign lastAns  = ansWr && (total == CW'(3));
  assign errNow   = errSeen || (ansWr && !ansOk);
  assign done     = lastAns || win2End;

  always_comb begin
    strobe           = '0;
    strobe.cycleDone = done;
    if (lastAns && !inWin2) begin
      strobe.flags.early  = 1'b1;
      strobe.flags.ansErr = errNow;
    end else if (lastAns) begin
      strobe.flags.seqErr = (cntW1 < CW'(3));
      strobe.flags.ansErr = errNow;
      strobe.cyclePass    = (cntW1 == CW'(3)) && !errNow;
    end else if (win2End) begin
      strobe.flags.timeout = 1'b1;
      strobe.flags.seqErr  = (cntW1 < CW'(3));
      strobe.flags.ansErr  = errNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || done) begin
      inWin2  <= 1'b0;
      timer   <= '0;
      cntW1   <= '0;
      cntW2   <= '0;
      errSeen <= 1'b0;
      ansIdx  <= '1;
    end else begin
      if (ansWr) begin
        if (inWin2) cntW2 <= cntW2 + CW'(1);
        else        cntW1 <= cntW1 + CW'(1);
        ansIdx  <= ansIdx - INDEX_W'(1);
        errSeen <= errNow;
      end
      if (win1End) begin
        inWin2 <= 1'b1;
        timer  <= '0;
      end else begin
        timer <= timer + TIMER_W'(1);
      end
    end
  end

  // R3: a write that does not close the cycle steps the index down by one
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    ansWr && !done |=> ansIdx == INDEX_W'($past(ansIdx) - INDEX_W'(1)));

  // R5: a pass can only be signalled on a correct write
  a_r5_pass_on_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cyclePass |-> ansWr && ansOk);

  // R8: an ending without a write is always a timeout
  a_r8_timeout_flag: assert property (@(posedge clk) disable iff (!rstN)
    done && !ansWr |-> strobe.flags.timeout);
endmodule

// File: rtl/qaw_datapath.sv
module qaw_datapath
  import qaw_pkg::*;
#(
  parameter int FAIL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ANSWER_W-1:0]   ansByte,
  input  logic [INDEX_W-1:0]    ansIdx,
  input  logic                  statRd,
  input  qaw_strobe_t           strobe,
  input  logic [FAIL_W-1:0]     failThresh,
  output logic                  ansOk,
  output logic [QUESTION_W-1:0] question,
  output logic [3:0]            statusFlags,
  output logic [FAIL_W-1:0]     failCnt,
  output logic                  failHit,
  output logic                  cycleEnd
);
  localparam logic [FAIL_W-1:0] FAIL_MAX = '1;

  function automatic logic [ANSWER_W-1:0] answerFor(input logic [QUESTION_W-1:0] q,
                                                    input logic [INDEX_W-1:0] idx);
    logic [3:0] hi, lo;
    hi = {q[1:0], q[3:2]} ^ {4{idx[0]}};
    lo = {q[3:1], 1'b0} ^ {4{q[0]}} ^ {4{idx[1]}};
    return {hi, lo};
  endfunction

  function automatic logic [QUESTION_W-1:0] nextQuestion(input logic [QUESTION_W-1:0] q);
    return {q[2:0], q[3] ^ q[2] ^ (q[2:0] == 3'b000)};
  endfunction

  logic [3:0] newFlags;

  assign ansOk    = (ansByte == answerFor(question, ansIdx));
  assign newFlags = strobe.flags;
  assign failHit  = (failCnt >= failThresh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      question <= '0;
      failCnt  <= '0;
      cycleEnd <= 1'b0;
    end else begin
      cycleEnd <= strobe.cycleDone;
      if (strobe.cycleDone) begin
        if (strobe.cyclePass) begin
          question <= nextQuestion(question);
          if (failCnt != '0) failCnt <= failCnt - FAIL_W'(1);
        end else if (failCnt != FAIL_MAX) begin
          failCnt <= failCnt + FAIL_W'(1);
        end
      end
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                 statusFlags[b] <= 1'b0;
      else if (strobe.cycleDone) statusFlags[b] <= newFlags[b];
      else if (statRd)           statusFlags[b] <= 1'b0;
    end
  end

  // R10: a failing cycle keeps the question
  a_r10_fail_keeps_q: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cycleDone && !strobe.cyclePass |=> question == $past(question));

  // R5: a passing cycle moves to a different question
  a_r5_pass_moves_q: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cycleDone && strobe.cyclePass |=> question != $past(question));

  // R10: the counter moves only at cycle ends
  a_r10_cnt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cycleDone |=> failCnt == $past(failCnt));

  // R11: a read outside a cycle end clears the flags
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    statRd && !strobe.cycleDone |=> statusFlags == 4'b0000);

  // R13: the cycle-end pulse lasts one clock
  a_r13_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |=> !cycleEnd);
endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
  import qaw_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int FAIL_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ansWr,
  input  logic [7:0]         ansByte,
  input  logic               statRd,
  input  logic [TIMER_W-1:0] win1Len,
  input  logic [TIMER_W-1:0] win2Len,
  input  logic [FAIL_W-1:0]  failThresh,
  output logic [3:0]         question,
  output logic [1:0]         ansIdx,
  output logic [3:0]         statusFlags,
  output logic [FAIL_W-1:0]  failCnt,
  output logic               failHit,
  output logic               cycleEnd
);
  qaw_strobe_t strobe;
  logic        ansOk;

  qaw_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ansWr   (ansWr),
    .ansOk   (ansOk),
    .win1Len (win1Len),
    .win2Len (win2Len),
    .ansIdx  (ansIdx),
    .strobe  (strobe)
  );

  qaw_datapath #(.FAIL_W(FAIL_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ansByte     (ansByte),
    .ansIdx      (ansIdx),
    .statRd      (statRd),
    .strobe      (strobe),
    .failThresh  (failThresh),
    .ansOk       (ansOk),
    .question    (question),
    .statusFlags (statusFlags),
    .failCnt     (failCnt),
    .failHit     (failHit),
    .cycleEnd    (cycleEnd)
  );
endmodule

// File: tb/qa_watchdog_bench.sv
module qa_watchdog_bench;
  localparam int TIMER_W = 16;
  localparam int FAIL_W  = 3;
  localparam int W1      = 8;
  localparam int W2      = 8;
  localparam int THRESH  = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               ansWr = 1'b0;
  logic [7:0]         ansByte = '0;
  logic               statRd = 1'b0;
  logic [TIMER_W-1:0] win1Len = TIMER_W'(W1);
  logic [TIMER_W-1:0] win2Len = TIMER_W'(W2);
  logic [FAIL_W-1:0]  failThresh = FAIL_W'(THRESH);
  logic [3:0]         question;
  logic [1:0]         ansIdx;
  logic [3:0]         statusFlags;
  logic [FAIL_W-1:0]  failCnt;
  logic               failHit;
  logic               cycleEnd;

  int checks = 0;
  int fails  = 0;
  int modelQ = 0;
  int modelFail = 0;

  always #2 clk = ~clk;

  qa_watchdog #(.TIMER_W(TIMER_W), .FAIL_W(FAIL_W)) u_qa_watchdog (
    .clk(clk), .rstN(rstN), .ansWr(ansWr), .ansByte(ansByte), .statRd(statRd),
    .win1Len(win1Len), .win2Len(win2Len), .failThresh(failThresh),
    .question(question), .ansIdx(ansIdx), .statusFlags(statusFlags),
    .failCnt(failCnt), .failHit(failHit), .cycleEnd(cycleEnd)
  );

  function automatic int expAns(input int q, input int idx);
    int hi, lo;
    hi = (((q & 3) << 2) | (q >> 2)) ^ (((idx & 1) != 0) ? 15 : 0);
    lo = (q & 14) ^ (((q & 1) != 0) ? 15 : 0) ^ (((idx & 2) != 0) ? 15 : 0);
    return (hi << 4) | lo;
  endfunction

  function automatic int nextQ(input int q);
    int fb;
    fb = ((q >> 3) & 1) ^ ((q >> 2) & 1) ^ (((q & 7) == 0) ? 1 : 0);
    return ((q << 1) & 14) | fb;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called mid-clock in the first clock of a cycle; returns at the same point of the next.
  task automatic runCycle(input int n1, input int n2, input int errAt);
    int k, p, total, expLen, expFlags;
    bit doWr, er, pass;
    string tag;
    k = 0;
    p = 0;
    forever begin
      doWr = (p < n1) || (p >= W1 && p < W1 + n2);
      if (doWr) begin
        chk("R3 index", int'(ansIdx), 3 - k);
        ansByte = 8'(expAns(modelQ, 3 - k) ^ ((k == errAt) ? 8'h5A : 8'h00));
        ansWr   = 1'b1;
        k++;
      end
      statRd = (p == 0);
      @(negedge clk);
      ansWr  = 1'b0;
      statRd = 1'b0;
      p++;
      if (p == 1) begin
        chk("R11 read clear", int'(statusFlags), 0);
        chk("R13 pulse width", int'(cycleEnd), 0);
      end
      if (cycleEnd) break;
      if (p > W1 + W2 + 4) begin
        chk("R4 cycle never ended", 0, 1);
        break;
      end
    end
    total = n1 + n2;
    er    = (errAt >= 0) && (errAt < total);
    pass  = 1'b0;
    if (n1 == 4) begin
      tag      = "R6 early";
      expFlags = (int'(er) << 3) | 4;
      expLen   = 4;
    end else if (total == 4) begin
      pass     = (n1 == 3) && !er;
      tag      = pass ? "R5 pass" : "R7 sequence";
      expFlags = (int'(er) << 3) | ((n1 < 3) ? 2 : 0);
      expLen   = W1 + n2;
    end else begin
      tag      = "R8 timeout";
      expFlags = (int'(er) << 3) | ((n1 < 3) ? 2 : 0) | 1;
      expLen   = W1 + W2;
    end
    if (pass) begin
      modelQ = nextQ(modelQ);
      if (modelFail > 0) modelFail--;
    end else if (modelFail < 7) begin
      modelFail++;
    end
    chk("R4 cycle length", p, expLen);
    chk(tag, int'(statusFlags), expFlags);
    chk("R9 answer error", int'(statusFlags[3]), int'(er));
    chk(pass ? "R5 question" : "R10 question", int'(question), modelQ);
    chk(pass ? "R5 fail count" : "R10 fail count", int'(failCnt), modelFail);
    chk("R12 threshold", int'(failHit), (modelFail >= THRESH) ? 1 : 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 question", int'(question), 0);
    chk("R1 index", int'(ansIdx), 3);
    chk("R1 flags", int'(statusFlags), 0);
    chk("R1 fail count", int'(failCnt), 0);
    chk("R1 cycle end", int'(cycleEnd), 0);
    chk("R12 threshold at reset", int'(failHit), 0);
    rstN = 1'b1;
    // First cycle receives nothing: sequence error plus timeout.
    while (!cycleEnd) @(negedge clk);
    modelFail = 1;
    chk("R8 silent cycle", int'(statusFlags), 3);
    chk("R10 silent count", int'(failCnt), 1);
    chk("R10 silent question", int'(question), 0);

    for (int n1 = 0; n1 <= 4; n1++)
      for (int n2 = 0; n2 <= 4 - n1; n2++)
        for (int e = -1; e < n1 + n2; e++)
          runCycle(n1, n2, e);

    // R5 / R2: passes walk through every question and every answer byte.
    for (int i = 0; i < 20; i++) runCycle(3, 1, -1);
    chk("R5 full walk floor", int'(failCnt), 0);

    // R10: repeated failures saturate the counter.
    for (int i = 0; i < 9; i++) runCycle(4, 0, 1);
    chk("R10 ceiling", int'(failCnt), 7);
    runCycle(3, 1, -1);
    runCycle(3, 0, -1);
    runCycle(2, 2, -1);
    runCycle(3, 1, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule